// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block moves one byte at a time over a two-wire synchronous serial link made of a shift clock line and a data line. A small CPU-style bus gives access to a control register and a data register. Writing the data register loads the byte to send and arms a transfer. Eight bits are then shifted out while eight bits are shifted in on the same clock. When the eighth bit has been taken in, a completion flag is set and a one-cycle interrupt request pulse is raised. The received byte can then be read back from the data register.

The shift clock has two possible sources. In internal mode the block divides the system clock, drives the result on the clock pin and starts shifting as soon as the data register is written. In external mode the clock pin is an input. It is synchronized into the system clock domain and its edges are detected, and the transfer advances only on those edges once a data write has armed it. Output data changes on falling clock edges and input data is sampled on rising edges, and the clock idles high. The data pin can be released so that the block only receives, and bit order is selectable between least- and most-significant first.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, irq is 0, sck_out is 1, and both sck_oe and sd_oe are 0.
- R2: The control register has this layout: bits 2:0 are the divider select, bit 3 enables the data driver, bit 4 selects the bit order and bit 6 selects the internal clock. Bit 5 always reads 0. Bit 7 is the read-only completion flag, and writes to it are ignored. Address 0 selects the control register and address 1 selects the data register.
- R3: In internal mode the shift clock half period is 4, 8, 16, 32, 64 or 128 system cycles for select codes 000, 001, 010, 011, 110 and 111. Code 100 acts as 110 and code 101 acts as 111. A whole transfer therefore lasts 16 half periods.
- R4: In internal mode sck_out stays high while idle and through the first half period after the data write edge. It falls at the end of that half period, and irq appears exactly 16 half periods after the write edge.
- R5: With bit 4 = 0 the bits of the written byte appear on sd_out least-significant first. Each bit is valid at the rising clock edge.
- R6: With bit 4 = 1 the bits appear most-significant first.
- R7: sd_in is sampled at each rising edge of the shift clock. After completion the data register reads the received byte, with the first received bit placed at bit 0 in LSB-first order and at bit 7 in MSB-first order.
- R8: When the eighth bit is sampled, the completion flag becomes 1 and irq is high for exactly one system cycle.
- R9: Any write to the data register clears the completion flag. A write to the control register leaves the flag unchanged.
- R10: sd_oe equals control bit 3. With bit 3 = 0 the block still receives correctly.
- R11: sck_oe equals control bit 6. In external mode sck_out stays at 1.
- R12: In external mode, clock edges are ignored until a data write arms a transfer. After that the block shifts on the synchronized edges of sck_in, and irq appears on the third system clock edge after the eighth rising edge of sck_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write enable for the access |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_in | input | 1 | Shift clock from the pin, used in external mode |
| sck_out | output | 1 | Shift clock driven in internal mode |
| sck_oe | output | 1 | Clock pin driver enable |
| sd_in | input | 1 | Serial data from the pin |
| sd_out | output | 1 | Serial data to the pin |
| sd_oe | output | 1 | Data pin driver enable |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
In internal mode every result is tied to the edge that samples the data write. The first clock fall is due one half period after that edge and irq is due 16 half periods after it. The bench counts falling system edges from the write and compares at exactly those counts. In external mode irq is due on the third system edge after the bench raises sck_in for the eighth time, because two synchronizer stages and one edge-history stage lie on the way. The bench looks at irq on each of those three edges. Serial bits are checked by a scoreboard at each rising edge of the line clock, several system cycles after the falling edge that last changed sd_out.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int SEL_W  = 3;
    localparam int HALF_W = 8;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_DATA = 1'b1
    } ssp_addr_e;

    typedef struct packed {
        logic             int_clk;
        logic             spare;
        logic             msb_first;
        logic             sd_drive;
        logic [SEL_W-1:0] div_sel;
    } ssp_ctrl_t;

    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        logic [HALF_W-1:0] h;
        case (sel)
            3'b000:          h = HALF_W'(4);
            3'b001:          h = HALF_W'(8);
            3'b010:          h = HALF_W'(16);
            3'b011:          h = HALF_W'(32);
            3'b100, 3'b110:  h = HALF_W'(64);
            default:         h = HALF_W'(128);
        endcase
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] shift_step(input logic [DATA_W-1:0] sr,
                                                     input logic din,
                                                     input logic msb);
        return msb ? {sr[DATA_W-2:0], din} : {din, sr[DATA_W-1:1]};
    endfunction

    function automatic logic lead_bit(input logic [DATA_W-1:0] sr, input logic msb);
        return msb ? sr[DATA_W-1] : sr[0];
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_mode,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             busy,
    input  logic             start,
    input  logic             sck_pin_in,
    input  logic             sd_pin_in,
    output logic             sck_line,
    output logic             rise,
    output logic             fall,
    output logic             sd_sample
);
    localparam int HIST = SYNC_STAGES;

    logic [HALF_W-1:0] cnt_q;
    logic              sck_q;
    logic [HALF_W-1:0] half;
    logic              tick;
    logic [HIST:0]     sck_sync_q;
    logic [SYNC_STAGES-1:0] sd_sync_q;
    logic              ext_rise, ext_fall;

    assign half = half_period(div_sel);
    assign tick = int_mode && busy && !start && (cnt_q == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !busy || start || !int_mode) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sync_q <= '1;
                    sd_sync_q  <= '0;
                end else begin
                    sck_sync_q <= {sck_sync_q[HIST-1:0], sck_pin_in};
                    sd_sync_q  <= {sd_sync_q[SYNC_STAGES-2:0], sd_pin_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sync_q <= '1;
                    sd_sync_q  <= '0;
                end else begin
                    sck_sync_q <= {sck_sync_q[HIST-1:0], sck_pin_in};
                    sd_sync_q  <= sd_pin_in;
                end
            end
        end
    endgenerate

    assign ext_rise  = sck_sync_q[HIST-1] && !sck_sync_q[HIST];
    assign ext_fall  = !sck_sync_q[HIST-1] && sck_sync_q[HIST];

    assign rise      = int_mode ? (tick && !sck_q) : (busy && !start && ext_rise);
    assign fall      = int_mode ? (tick && sck_q)  : (busy && !start && ext_fall);
    assign sd_sample = int_mode ? sd_pin_in : sd_sync_q[SYNC_STAGES-1];
    assign sck_line  = sck_q;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic              msb_first,
    input  logic              rise,
    input  logic              fall,
    input  logic              sd_sample,
    output logic [DATA_W-1:0] shreg,
    output logic              sd_bit,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  bit_q;
    logic              busy_q;
    logic              out_q;

    assign done = busy_q && !start && rise && (bit_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            out_q  <= 1'b0;
        end else if (start) begin
            sr_q   <= load_data;
            bit_q  <= '0;
            busy_q <= 1'b1;
            out_q  <= lead_bit(load_data, msb_first);
        end else if (busy_q) begin
            if (rise) begin
                sr_q  <= shift_step(sr_q, sd_sample, msb_first);
                bit_q <= bit_q + 1'b1;
                if (bit_q == LAST) begin
                    busy_q <= 1'b0;
                end
            end else if (fall) begin
                out_q <= lead_bit(sr_q, msb_first);
            end
        end
    end

    assign shreg  = sr_q;
    assign sd_bit = out_q;
    assign busy   = busy_q;

endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] shreg,
    input  logic              done,
    output logic [DATA_W-1:0] bus_rdata,
    output ssp_ctrl_t         ctrl,
    output logic              start,
    output logic              flag,
    output logic              irq
);
    ssp_ctrl_t ctrl_q;
    logic      flag_q;
    logic      irq_q;
    logic      ctrl_wr;
    logic      data_wr;
    logic      unused_wbits;

    assign ctrl_wr      = bus_sel && bus_wr && (ssp_addr_e'(bus_addr) == ADDR_CTRL);
    assign data_wr      = bus_sel && bus_wr && (ssp_addr_e'(bus_addr) == ADDR_DATA);
    assign unused_wbits = ^{bus_wdata[7], bus_wdata[5]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.int_clk   <= bus_wdata[6];
            ctrl_q.spare     <= 1'b0;
            ctrl_q.msb_first <= bus_wdata[4];
            ctrl_q.sd_drive  <= bus_wdata[3];
            ctrl_q.div_sel   <= bus_wdata[2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done && !data_wr;
            if (data_wr) begin
                flag_q <= 1'b0;
            end else if (done) begin
                flag_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (ssp_addr_e'(bus_addr) == ADDR_CTRL) begin
            bus_rdata = {flag_q, ctrl_q};
        end else begin
            bus_rdata = shreg;
        end
    end

    assign ctrl  = ctrl_q;
    assign start = data_wr;
    assign flag  = flag_q;
    assign irq   = irq_q;

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              irq
);
    ssp_ctrl_t         ctrl;
    logic              start;
    logic              flag_q;
    logic              busy;
    logic              done;
    logic              rise, fall;
    logic              sd_sample;
    logic              sck_line;
    logic              sd_bit;
    logic [DATA_W-1:0] shreg;

    ssp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .shreg     (shreg),
        .done      (done),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .start     (start),
        .flag      (flag_q),
        .irq       (irq)
    );

    ssp_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .int_mode   (ctrl.int_clk),
        .div_sel    (ctrl.div_sel),
        .busy       (busy),
        .start      (start),
        .sck_pin_in (sck_in),
        .sd_pin_in  (sd_in),
        .sck_line   (sck_line),
        .rise       (rise),
        .fall       (fall),
        .sd_sample  (sd_sample)
    );

    ssp_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_data (bus_wdata),
        .msb_first (ctrl.msb_first),
        .rise      (rise),
        .fall      (fall),
        .sd_sample (sd_sample),
        .shreg     (shreg),
        .sd_bit    (sd_bit),
        .busy      (busy),
        .done      (done)
    );

    assign sck_out = ctrl.int_clk ? sck_line : 1'b1;
    assign sck_oe  = ctrl.int_clk;
    assign sd_out  = sd_bit;
    assign sd_oe   = ctrl.sd_drive;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_rdata,
    input logic       sck_out,
    input logic       sck_oe,
    input logic       sd_out,
    input logic       irq,
    input logic       busy,
    input logic       flag_q
);
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_with_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);

    p_busy_end_irq_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    p_data_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr) |=> !flag_q);

    p_clock_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && !busy) |-> sck_out);

    p_sd_moves_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && busy && $past(busy) && !$stable(sd_out)) |-> $fell(sck_out));

    p_spare_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> !bus_rdata[5]);

endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .sd_out    (sd_out),
    .irq       (irq),
    .busy      (busy),
    .flag_q    (flag_q)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_drv = 1'b1;
    logic       sck_out, sck_oe;
    logic       sd_in;
    logic       sd_out, sd_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic  exp_q[$];
    bit    mon_en = 0;
    string mon_req = "R5";
    bit    rx_active = 0;
    bit    rx_msb = 0;
    logic [7:0] rx_byte = 8'h00;
    int    rx_idx = -1;
    logic  line_sck;

    sync_serial_port u_sync_serial_port (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck_in    (sck_drv),
        .sck_out   (sck_out),
        .sck_oe    (sck_oe),
        .sd_in     (sd_in),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_sck = sck_oe ? sck_out : sck_drv;
    assign sd_in = (rx_idx >= 0 && rx_idx < 8) ?
                   (rx_msb ? rx_byte[7 - rx_idx] : rx_byte[rx_idx]) : 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each rising line clock pops one expected serial bit
    always @(posedge line_sck) begin
        if (mon_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, mon_req, int'(sd_out), 2);
            end else begin
                logic e_bit;
                e_bit = exp_q.pop_front();
                check(sd_out === e_bit, mon_req, int'(sd_out), int'(e_bit));
            end
        end
    end

    always @(negedge line_sck) begin
        if (rx_active) rx_idx <= rx_idx + 1;
    end

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int exp_half(input logic [2:0] sel);
        case (sel)
            3'b000: return 4;
            3'b001: return 8;
            3'b010: return 16;
            3'b011: return 32;
            3'b100: return 64;
            3'b110: return 64;
            default: return 128;
        endcase
    endfunction

    task automatic push_tx(input logic [7:0] tx, input bit msb);
        for (int i = 0; i < 8; i++) exp_q.push_back(msb ? tx[7-i] : tx[i]);
    endtask

    task automatic run_internal(input logic [2:0] sel, input bit msb, input bit drive,
                                input logic [7:0] tx, input logic [7:0] rx, input string req);
        int h;
        int n;
        int at;
        logic [7:0] rd;
        h = exp_half(sel);
        bus_write(1'b0, {1'b0, 1'b1, 1'b0, msb, drive, sel});
        check(sck_oe === 1'b1, "R11 sck_oe internal", int'(sck_oe), 1);
        check(sd_oe === drive, "R10 sd_oe follows bit3", int'(sd_oe), int'(drive));
        exp_q.delete();
        if (drive) push_tx(tx, msb);
        mon_req = req;
        mon_en = drive;
        rx_byte = rx; rx_msb = msb; rx_idx = -1; rx_active = 1;
        bus_write(1'b1, tx);
        n = 0; at = -1;
        while (at < 0 && n < 16*h + 8) begin
            @(negedge clk);
            n++;
            if (n == h-1) check(sck_out === 1'b1, "R4 clock high before first fall", int'(sck_out), 1);
            if (n == h)   check(sck_out === 1'b0, "R4 first fall after half period", int'(sck_out), 0);
            if (irq === 1'b1) at = n;
        end
        check(at == 16*h, "R3 R4 transfer length", at, 16*h);
        @(negedge clk);
        check(irq === 1'b0, "R8 irq single cycle", int'(irq), 0);
        mon_en = 0; rx_active = 0;
        check(exp_q.size() == 0, "R5 R6 all bits shifted", exp_q.size(), 0);
        bus_read(1'b0, rd);
        check(rd[7] === 1'b1, "R8 flag set", int'(rd[7]), 1);
        bus_read(1'b1, rd);
        check(rd === rx, "R7 received byte", int'(rd), int'(rx));
    endtask

    task automatic ext_toggle(input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk); sck_drv = 1'b0;
            repeat (8) @(negedge clk);
            sck_drv = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(1'b0, rd);
        check(rd === 8'h00, "R1 ctrl reset", int'(rd), 0);
        check(irq === 1'b0, "R1 irq reset", int'(irq), 0);
        check(sck_out === 1'b1, "R1 sck idle", int'(sck_out), 1);
        check(sck_oe === 1'b0 && sd_oe === 1'b0, "R1 drivers off", int'({sck_oe, sd_oe}), 0);

        // R2 layout, spare and flag not writable
        bus_write(1'b0, 8'hFF);
        bus_read(1'b0, rd);
        check(rd === 8'h5F, "R2 ctrl readback", int'(rd), 8'h5F);
        bus_write(1'b0, 8'h00);

        run_internal(3'b000, 1'b0, 1'b1, 8'hA5, 8'h3C, "R5 LSB first");
        run_internal(3'b001, 1'b1, 1'b1, 8'h1E, 8'hC9, "R6 MSB first");
        run_internal(3'b010, 1'b0, 1'b0, 8'h77, 8'h96, "R10 receive only");
        run_internal(3'b011, 1'b0, 1'b1, 8'h5A, 8'h81, "R3 div 011");
        run_internal(3'b100, 1'b1, 1'b1, 8'h5A, 8'h81, "R3 div 100");
        run_internal(3'b101, 1'b0, 1'b1, 8'h5A, 8'h81, "R3 div 101");
        run_internal(3'b110, 1'b1, 1'b1, 8'h5A, 8'h42, "R3 div 110");
        run_internal(3'b111, 1'b0, 1'b1, 8'h5A, 8'h81, "R3 div 111");

        // external mode, MSB first, driving data
        bus_write(1'b0, 8'h18);
        check(sck_oe === 1'b0, "R11 sck_oe external", int'(sck_oe), 0);
        check(sck_out === 1'b1, "R11 sck_out held", int'(sck_out), 1);
        bus_read(1'b0, rd);
        check(rd === 8'h98, "R9 ctrl write keeps flag", int'(rd), 8'h98);
        ext_toggle(3);
        bus_read(1'b1, rd);
        check(rd === 8'h81, "R12 idle edges ignored data", int'(rd), 8'h81);
        bus_read(1'b0, rd);
        check(rd[7] === 1'b1, "R12 idle edges keep flag", int'(rd[7]), 1);

        exp_q.delete();
        push_tx(8'hC3, 1'b1);
        mon_req = "R12 external bits";
        rx_byte = 8'h6B; rx_msb = 1'b1; rx_idx = -1;
        bus_write(1'b1, 8'hC3);
        bus_read(1'b0, rd);
        check(rd[7] === 1'b0, "R9 data write clears flag", int'(rd[7]), 0);
        mon_en = 1; rx_active = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_drv = 1'b0;
            repeat (8) @(negedge clk);
            sck_drv = 1'b1;
            if (i < 7) repeat (8) @(negedge clk);
        end
        @(negedge clk);
        check(irq === 1'b0, "R12 irq not after first edge", int'(irq), 0);
        @(negedge clk);
        check(irq === 1'b0, "R12 irq not after second edge", int'(irq), 0);
        @(negedge clk);
        check(irq === 1'b1, "R12 irq on third edge", int'(irq), 1);
        @(negedge clk);
        check(irq === 1'b0, "R8 irq single cycle external", int'(irq), 0);
        mon_en = 0; rx_active = 0;
        check(exp_q.size() == 0, "R12 all bits shifted", exp_q.size(), 0);
        bus_read(1'b1, rd);
        check(rd === 8'h6B, "R7 R12 external received byte", int'(rd), 8'h6B);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule